// File: doc/BRIEF.md
# Periodic Quadrature Tachometer Sequencer

This block drives an external quadrature-counter chip over a four-wire serial link (SPI mode 0, 8-bit transfers) and turns it into a periodic tachometer. After reset it runs a fixed set-up script. The script clears the counter, loads it, selects x4 quadrature counting, writes a 32-bit zero into the chip's transfer register, and then loads the counter from that register. After set-up it waits for an internal period tick. On each tick it freezes the counter into the chip's snapshot register and reads the 32-bit value back.

The value read back is sign-inverted and presented as the position count. The block also gives the difference from the count of the previous sample. A one-cycle strobe marks each new pair. Chip select stays low for a settling gap before the first serial clock of every transaction. It stays high for the same gap between transactions. A channel input chooses which of two active-low chip selects is used. Scaling the difference into physical speed is left to downstream logic.

Top module: `enc_tach_seq`

## Requirements
- R1: Each command byte carries the operation in bits 7:6 (clear 0, read 1, write 2, load 3) and the register in bits 5:3 (mode 1, transfer 3, counter 4, snapshot 5), with bits 2:0 zero.
- R2: After reset the set-up script sends five transactions, in this order: {0x20}, {0xE0}, {0x88, 0x03}, {0x98, 0x00, 0x00, 0x00, 0x00}, {0xE0}. Multi-byte data goes most significant byte first.
- R3: Each sample is two transactions: {0xE8} and then {0x60 followed by four received bytes}. Chip select is released between the two.
- R4: The four received bytes form a word with the first byte as the most significant. `count_out` is the two's-complement negation of that word.
- R5: `delta_out` equals the new `count_out` minus the `count_out` of the previous sample. Before the first sample the previous count is zero.
- R6: `sample_valid` is high for exactly one cycle per sample, in the cycle in which `count_out` and `delta_out` take their new values. Both outputs hold between strobes.
- R7: A `chan_sel` value of 2, taken when a transaction group starts, drives `cs_b_n`. Any other value drives `cs_a_n`. The two are never low together.
- R8: SCK idles low while both chip selects are high. Chip select is low for at least GAP_CLKS cycles before the first SCK rise, and high for at least GAP_CLKS cycles between transactions.
- R9: Samples start every PERIOD_CLKS cycles once set-up is complete, so strobes are exactly PERIOD_CLKS apart. A tick that arrives while a transfer sequence is active is dropped and sets the sticky `overrun` flag.
- R10: During reset both chip selects are high, SCK is low, and `count_out`, `delta_out`, `sample_valid` and `overrun` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_sel | input | 2 | Channel choice; 2 selects `cs_b_n` |
| miso | input | 1 | Serial data from the counter chip |
| sck | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data to the counter chip |
| cs_a_n | output | 1 | First chip select, active low |
| cs_b_n | output | 1 | Second chip select, active low |
| count_out | output | 32 | Negated counter value of the last sample |
| delta_out | output | 32 | Count difference from the previous sample |
| sample_valid | output | 1 | One-cycle strobe for a new sample |
| overrun | output | 1 | Sticky flag: a period tick was dropped |

## Verification
The bench models the counter chip and records every byte and chip-select pulse, so the exact set-up and sample byte streams are compared. A wrong script order or wrong field packing shows up as a mismatched byte. The returned words include zero, the most negative value, the largest positive value and a negative raw value. Getting the byte order or the negation wrong yields a wrong count; getting the old-count update wrong yields a wrong delta. The channel is switched between samples, which exposes a chip select that is decoded wrongly or latched at the wrong time. A second instance with a period shorter than one read must raise `overrun`, while the main instance must keep exact strobe spacing and chip-select gaps no shorter than the settling time.

// File: rtl/enc_tach_pkg.sv
package enc_tach_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned STEP_W = 3;

  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_LOAD  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    RG_MODE  = 3'd1,
    RG_XFER  = 3'd3,
    RG_COUNT = 3'd4,
    RG_SNAP  = 3'd5
  } reg_e;

  typedef enum logic [1:0] {
    S_GAPHI,
    S_SETTLE,
    S_XFER,
    S_IDLE
  } seq_state_e;

  // script steps: 0..4 set-up, 5 snapshot, 6 fetch
  localparam logic [STEP_W-1:0] STEP_LAST_INIT = 3'd4;
  localparam logic [STEP_W-1:0] STEP_SNAP      = 3'd5;
  localparam logic [STEP_W-1:0] STEP_FETCH     = 3'd6;

  function automatic logic [7:0] cmd_byte(input op_e op, input reg_e rg);
    return {op, rg, 3'b000};
  endfunction

  // bytes in each transaction of the script
  function automatic logic [2:0] script_len(input logic [STEP_W-1:0] step);
    case (step)
      3'd2:    return 3'd2;
      3'd3:    return 3'd5;
      3'd6:    return 3'd5;
      default: return 3'd1;
    endcase
  endfunction

  // byte sent at position idx of a step (payload of the zero write is all zero)
  function automatic logic [7:0] script_byte(input logic [STEP_W-1:0] step,
                                             input logic [2:0] idx);
    if (idx != 3'd0) begin
      return (step == 3'd2) ? 8'h03 : 8'h00;
    end
    case (step)
      3'd0:    return cmd_byte(OP_CLEAR, RG_COUNT);
      3'd1:    return cmd_byte(OP_LOAD,  RG_COUNT);
      3'd2:    return cmd_byte(OP_WRITE, RG_MODE);
      3'd3:    return cmd_byte(OP_WRITE, RG_XFER);
      3'd4:    return cmd_byte(OP_LOAD,  RG_COUNT);
      3'd5:    return cmd_byte(OP_LOAD,  RG_SNAP);
      default: return cmd_byte(OP_READ,  RG_COUNT);
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] negate_word(input logic [WORD_W-1:0] w);
    return ~w + 1'b1;
  endfunction

  function automatic logic [WORD_W-1:0] step_delta(input logic [WORD_W-1:0] now_c,
                                                   input logic [WORD_W-1:0] old_c);
    return now_c - old_c;
  endfunction

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int unsigned HALF_CLKS = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int unsigned HW = $clog2(HALF_CLKS + 1);
  localparam logic [HW-1:0] HALF_LAST = HW'(HALF_CLKS - 1);

  logic [HW-1:0] half_cnt;
  logic [2:0]    bit_n;
  logic [7:0]    tx_sr;
  logic [7:0]    rx_sr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      sck      <= 1'b0;
      done     <= 1'b0;
      half_cnt <= '0;
      bit_n    <= '0;
      tx_sr    <= '0;
      rx_sr    <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy     <= 1'b1;
          tx_sr    <= tx_byte;
          half_cnt <= '0;
          bit_n    <= '0;
        end
      end else if (half_cnt == HALF_LAST) begin
        half_cnt <= '0;
        if (!sck) begin
          sck   <= 1'b1;
          rx_sr <= {rx_sr[6:0], miso};
        end else begin
          sck <= 1'b0;
          if (bit_n == 3'd7) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bit_n <= bit_n + 3'd1;
            tx_sr <= {tx_sr[6:0], 1'b0};
          end
        end
      end else begin
        half_cnt <= half_cnt + 1'b1;
      end
    end
  end

  assign mosi    = tx_sr[7];
  assign rx_byte = rx_sr;
endmodule

// File: rtl/tach_period_timer.sv
module tach_period_timer #(
  parameter int unsigned PERIOD_CLKS = 625000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic tick
);
  localparam int unsigned PW = $clog2(PERIOD_CLKS + 1);
  localparam logic [PW-1:0] P_LAST = PW'(PERIOD_CLKS - 1);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable)   cnt <= '0;
    else if (cnt == P_LAST)  cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  assign tick = enable && (cnt == P_LAST);
endmodule

// File: rtl/enc_tach_seq.sv
module enc_tach_seq
  import enc_tach_pkg::*;
#(
  parameter int unsigned HALF_SCK_CLKS = 25,
  parameter int unsigned GAP_CLKS      = 100,
  parameter int unsigned PERIOD_CLKS   = 625000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  chan_sel,
  input  logic        miso,
  output logic        sck,
  output logic        mosi,
  output logic        cs_a_n,
  output logic        cs_b_n,
  output logic [31:0] count_out,
  output logic [31:0] delta_out,
  output logic        sample_valid,
  output logic        overrun
);
  localparam int unsigned GW = $clog2(GAP_CLKS + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CLKS - 1);

  seq_state_e        state;
  logic [STEP_W-1:0] step;
  logic [2:0]        byte_idx;
  logic [GW-1:0]     gap_cnt;
  logic              cs_act;
  logic              use_b;
  logic              xfer_start;
  logic              init_done;
  logic [WORD_W-1:0] rx_word;

  // named internal events
  logic              tick;
  logic              xfer_done;
  logic              shifter_busy;
  logic [7:0]        rx_byte;
  logic              seq_busy;
  logic              last_byte;
  logic [WORD_W-1:0] word_next;
  logic [WORD_W-1:0] count_next;

  assign seq_busy   = (state != S_IDLE);
  assign last_byte  = xfer_done && (byte_idx == script_len(step) - 3'd1);
  assign word_next  = {rx_word[WORD_W-9:0], rx_byte};
  assign count_next = negate_word(word_next);

  spi_byte_shifter #(.HALF_CLKS(HALF_SCK_CLKS)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (xfer_start),
    .tx_byte (script_byte(step, byte_idx)),
    .miso    (miso),
    .sck     (sck),
    .mosi    (mosi),
    .busy    (shifter_busy),
    .done    (xfer_done),
    .rx_byte (rx_byte)
  );

  tach_period_timer #(.PERIOD_CLKS(PERIOD_CLKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (init_done),
    .tick   (tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_GAPHI;
      step         <= '0;
      byte_idx     <= '0;
      gap_cnt      <= '0;
      cs_act       <= 1'b0;
      use_b        <= 1'b0;
      xfer_start   <= 1'b0;
      init_done    <= 1'b0;
      rx_word      <= '0;
      count_out    <= '0;
      delta_out    <= '0;
      sample_valid <= 1'b0;
      overrun      <= 1'b0;
    end else begin
      xfer_start   <= 1'b0;
      sample_valid <= 1'b0;
      if (tick && seq_busy) overrun <= 1'b1;
      case (state)
        S_GAPHI: begin
          if (gap_cnt == GAP_LAST) begin
            gap_cnt <= '0;
            cs_act  <= 1'b1;
            state   <= S_SETTLE;
            if (step == '0) use_b <= (chan_sel == 2'd2);
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        S_SETTLE: begin
          if (gap_cnt == GAP_LAST) begin
            gap_cnt    <= '0;
            byte_idx   <= '0;
            xfer_start <= 1'b1;
            state      <= S_XFER;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        S_XFER: begin
          if (xfer_done) begin
            if (step == STEP_FETCH) rx_word <= word_next;
            if (last_byte) begin
              cs_act <= 1'b0;
              if (step == STEP_FETCH) begin
                count_out    <= count_next;
                delta_out    <= step_delta(count_next, count_out);
                sample_valid <= 1'b1;
                step         <= STEP_SNAP;
                state        <= S_IDLE;
              end else if (step == STEP_LAST_INIT) begin
                init_done <= 1'b1;
                step      <= STEP_SNAP;
                state     <= S_IDLE;
              end else begin
                step  <= step + 1'b1;
                state <= S_GAPHI;
              end
            end else begin
              byte_idx   <= byte_idx + 3'd1;
              xfer_start <= 1'b1;
            end
          end
        end
        default: begin
          if (tick) begin
            use_b   <= (chan_sel == 2'd2);
            cs_act  <= 1'b1;
            gap_cnt <= '0;
            state   <= S_SETTLE;
          end
        end
      endcase
    end
  end

  assign cs_a_n = ~(cs_act && !use_b);
  assign cs_b_n = ~(cs_act && use_b);
endmodule

// File: rtl/enc_tach_seq_props.sv
module enc_tach_seq_props (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_a_n,
  input logic        cs_b_n,
  input logic        sck,
  input logic        sample_valid,
  input logic [31:0] count_out,
  input logic [31:0] delta_out,
  input logic        overrun,
  input logic        tick,
  input logic        seq_busy
);
  assert_cs_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cs_a_n && !cs_b_n));

  assert_sck_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_a_n && cs_b_n) |-> !sck);

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);

  assert_outputs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |-> ($stable(count_out) && $stable(delta_out)));

  assert_delta_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> (delta_out == count_out - $past(count_out)));

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  assert_overrun_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(tick && seq_busy));
endmodule

bind enc_tach_seq enc_tach_seq_props u_props (
  .clk          (clk),
  .rst_n        (rst_n),
  .cs_a_n       (cs_a_n),
  .cs_b_n       (cs_b_n),
  .sck          (sck),
  .sample_valid (sample_valid),
  .count_out    (count_out),
  .delta_out    (delta_out),
  .overrun      (overrun),
  .tick         (tick),
  .seq_busy     (seq_busy)
);

// File: tb/test_enc_tach_seq.sv
`timescale 1ns/1ps
module test_enc_tach_seq;
  localparam int HALF   = 50;
  localparam int GAP    = 200;
  localparam int PERIOD = 8000;
  localparam int NVEC   = 8;

  // {chan_sel, raw word returned by the modelled chip}
  localparam logic [33:0] VEC [0:NVEC-1] = '{
    {2'd0, 32'h0000_0000}, {2'd0, 32'h0000_0005}, {2'd1, 32'h0000_0010},
    {2'd2, 32'hFFFF_FFF0}, {2'd2, 32'h8000_0000}, {2'd3, 32'h0000_0001},
    {2'd0, 32'h7FFF_FFFF}, {2'd0, 32'h1234_5678}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] chan_sel = 2'd0;
  logic miso_r = 1'b0;
  logic sck, mosi, cs_a_n, cs_b_n, sample_valid, overrun;
  logic [31:0] count_out, delta_out;
  logic o_sck, o_mosi, o_csa, o_csb, o_valid, o_ovr;
  logic [31:0] o_count, o_delta;

  always #2.5 clk = ~clk;

  enc_tach_seq #(.HALF_SCK_CLKS(HALF), .GAP_CLKS(GAP), .PERIOD_CLKS(PERIOD)) i_enc_tach_seq (
    .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel), .miso(miso_r),
    .sck(sck), .mosi(mosi), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n),
    .count_out(count_out), .delta_out(delta_out),
    .sample_valid(sample_valid), .overrun(overrun));

  // second instance: period shorter than one read, so ticks must be dropped
  enc_tach_seq #(.HALF_SCK_CLKS(HALF), .GAP_CLKS(GAP), .PERIOD_CLKS(3000)) i_ovr (
    .clk(clk), .rst_n(rst_n), .chan_sel(2'd0), .miso(1'b0),
    .sck(o_sck), .mosi(o_mosi), .cs_a_n(o_csa), .cs_b_n(o_csb),
    .count_out(o_count), .delta_out(o_delta),
    .sample_valid(o_valid), .overrun(o_ovr));

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // ---- model of the counter chip ----
  logic cs_any_n;
  assign cs_any_n = cs_a_n & cs_b_n;
  logic [31:0] model_raw = 32'h0;
  logic [7:0]  sh = 8'h0;
  int bitc = 0;
  bit rd_mode = 1'b0;
  logic [7:0] byte_log [0:255];
  int nlog = 0;
  bit trans_b [0:63];
  int ntr = 0;
  realtime t_fall = 0, t_rise = 0;
  bit first_pending = 1'b0;
  bit seen_rise = 1'b0;
  realtime min_settle = 1.0e9, min_high = 1.0e9;

  always @(negedge cs_any_n) begin
    bitc = 0;
    rd_mode = 1'b0;
    if (ntr < 64) trans_b[ntr] = !cs_b_n;
    ntr++;
    t_fall = $realtime;
    first_pending = 1'b1;
    if (seen_rise && (t_fall - t_rise) < min_high) min_high = t_fall - t_rise;
  end

  always @(posedge cs_any_n) begin
    if (rst_n) begin
      t_rise = $realtime;
      seen_rise = 1'b1;
    end
  end

  always @(posedge sck) begin
    if (!cs_any_n) begin
      if (first_pending) begin
        first_pending = 1'b0;
        if (($realtime - t_fall) < min_settle) min_settle = $realtime - t_fall;
      end
      sh = {sh[6:0], mosi};
      bitc++;
      if (bitc % 8 == 0) begin
        if (nlog < 256) byte_log[nlog] = sh;
        nlog++;
        if (bitc == 8) rd_mode = (sh == 8'h60);
      end
    end
  end

  always @(negedge sck) begin
    if (!cs_any_n && rd_mode && bitc >= 8 && bitc < 40) miso_r <= model_raw[39 - bitc];
  end

  // ---- checking helpers ----
  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_valid(output bit got);
    got = 1'b0;
    for (int k = 0; k < 3 * PERIOD; k++) begin
      @(negedge clk);
      if (sample_valid) begin
        got = 1'b1;
        break;
      end
    end
  endtask

  function automatic logic [7:0] init_byte(input int k);
    case (k)
      0: return 8'h20;
      1: return 8'hE0;
      2: return 8'h88;
      3: return 8'h03;
      4: return 8'h98;
      9: return 8'hE0;
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    repeat (3 * PERIOD * (NVEC + 4)) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete (actual hung, expected done)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp_count, prev_count, exp_delta;
    longint last_valid_cyc;
    int base_log, base_tr;
    bit got;

    model_raw = VEC[0][31:0];
    chan_sel  = VEC[0][33:32];
    repeat (4) @(negedge clk);
    // R10 reset state
    check(cs_a_n && cs_b_n, "R10", "chip selects high in reset", {cs_b_n, cs_a_n}, 3);
    check(!sck, "R10", "sck low in reset", sck, 0);
    check(count_out == 0 && delta_out == 0, "R10", "outputs zero in reset", count_out | delta_out, 0);
    check(!sample_valid && !overrun, "R10", "flags low in reset", {overrun, sample_valid}, 0);
    rst_n = 1'b1;

    // wait until the set-up script (10 bytes, 5 transactions) is done
    for (int k = 0; k < 20 * PERIOD; k++) begin
      @(negedge clk);
      if (nlog >= 10 && cs_any_n) break;
    end
    repeat (2) @(negedge clk);
    for (int k = 0; k < 10; k++)
      check(byte_log[k] == init_byte(k), "R2", $sformatf("set-up byte %0d (R1 packing)", k),
            byte_log[k], init_byte(k));
    check(ntr == 5, "R2", "set-up transaction count", ntr, 5);
    for (int k = 0; k < 5; k++)
      check(!trans_b[k], "R7", "set-up uses first chip select", trans_b[k], 0);

    prev_count = 0;
    last_valid_cyc = 0;
    for (int i = 0; i < NVEC; i++) begin
      base_log = nlog;
      base_tr  = ntr;
      wait_valid(got);
      check(got, "R9", $sformatf("strobe arrives for vector %0d", i), got, 1);
      exp_count = ~VEC[i][31:0] + 32'd1;
      exp_delta = exp_count - prev_count;
      check(count_out == exp_count, "R4", $sformatf("negated count vec %0d", i), count_out, exp_count);
      check(delta_out == exp_delta, "R5", $sformatf("delta vec %0d", i), delta_out, exp_delta);
      check(byte_log[base_log] == 8'hE8, "R3", "snapshot command", byte_log[base_log], 8'hE8);
      check(byte_log[base_log + 1] == 8'h60, "R3", "fetch command", byte_log[base_log + 1], 8'h60);
      check(nlog - base_log == 6 && ntr - base_tr == 2, "R3", "two transactions, six bytes",
            nlog - base_log, 6);
      check(trans_b[base_tr] == (VEC[i][33:32] == 2'd2) && trans_b[base_tr + 1] == (VEC[i][33:32] == 2'd2),
            "R7", $sformatf("chip select for chan %0d", VEC[i][33:32]), trans_b[base_tr],
            VEC[i][33:32] == 2'd2);
      if (i > 0)
        check(cyc - last_valid_cyc == PERIOD, "R9", "strobe spacing", cyc - last_valid_cyc, PERIOD);
      last_valid_cyc = cyc;
      prev_count = exp_count;
      // next stimulus, well before the next tick
      if (i + 1 < NVEC) begin
        model_raw = VEC[i + 1][31:0];
        chan_sel  = VEC[i + 1][33:32];
      end
      @(negedge clk);
      check(!sample_valid, "R6", "strobe lasts one cycle", sample_valid, 0);
      repeat (50) @(negedge clk);
      check(count_out == exp_count && delta_out == exp_delta, "R6", "outputs hold after strobe",
            count_out, exp_count);
    end

    check(min_settle >= GAP * 5.0, "R8", "settle before first sck (ns)", longint'(min_settle), GAP * 5);
    check(min_high >= GAP * 5.0, "R8", "chip select high gap (ns)", longint'(min_high), GAP * 5);
    check(!overrun, "R9", "no overrun with long period", overrun, 0);
    check(o_ovr, "R9", "overrun set with short period", o_ovr, 1);
    check(o_count == 0, "R4", "zero word gives zero count", o_count, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule